// File: doc/BRIEF.md
# Board Control and Identification Port Block

This block sits on a byte-wide I/O-port bus and gives a small PC-style board its control levels and identification bytes. A write to a control port updates a level that leaves the block: soft-reset request, little-endian mode, disk activity lamp, a 4-bit system control field, and the I/O map mode bit that the address bridge decodes. Two ports give no stored state at all. A write to either one produces a single-clock toggle pulse toward the external non-volatile memory lock logic.

Several ports return fixed identification codes and ignore writes. Reads of ports with no read meaning return all ones. A write to a port the block does not accept raises a one-cycle error flag. Read data is registered: it appears on the data output after the clock edge that samples the read strobe and stays there until the next read.

Top module: `sysport_ctrl`

## Requirements
- R1: After reset, every control output, both lock pulses, the error flag and the read data are 0. Ports 0x81C and 0x850 then read 0x00.
- R2: A write to port 0x092 sets soft_rst_o to data bit 0 and le_mode_o to data bit 1. A read of port 0x092 returns 0x00.
- R3: A write to port 0x808 sets disk_led_o to data bit 0.
- R4: A write of any value to port 0x810 makes nv_lock_pulse_o[0] high for exactly the one following clock cycle. A write to port 0x812 does the same on nv_lock_pulse_o[1]. The two bits are never high together.
- R5: A write to port 0x81C stores data bits 3:0 on sys_ctl_o. A read of 0x81C returns the stored value with the upper four bits 0.
- R6: A write to port 0x850 stores data bit 0 on io_noncontig_o, where 1 selects the non-contiguous map. A read of 0x850 returns that bit in bit 0 with the other bits 0.
- R7: Reads return these fixed codes: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x823 gives 0x03, and 0x818 gives 0x00.
- R8: Writes to 0x800, 0x802 and 0x803 change no output and raise no error. Those ports still read their fixed codes afterwards.
- R9: A read of any port not listed in R2, R5, R6 or R7 returns 0xFF. This includes 0x808, 0x812 and 0x814.
- R10: The accepted write ports are 0x092, 0x800, 0x802, 0x803, 0x808, 0x810, 0x812, 0x814, 0x81C and 0x850. A write to 0x814 has no effect. A write to any other port raises wr_err_o for exactly the one following cycle and changes nothing else.
- R11: bus_rdata takes its new value at the clock edge where bus_rd is high. It holds that value while bus_rd stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Port address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| soft_rst_o | output | 1 | Soft-reset request level |
| le_mode_o | output | 1 | Little-endian mode flag |
| disk_led_o | output | 1 | Disk activity lamp |
| nv_lock_pulse_o | output | 2 | Lock toggle pulses; bit 0 comes from port 0x810, bit 1 from port 0x812 |
| sys_ctl_o | output | 4 | System control field |
| io_noncontig_o | output | 1 | I/O map mode, 1 means non-contiguous |
| wr_err_o | output | 1 | One-cycle flag for a write to a port that is not accepted |

## Verification
The read side is tried with every identification port, the stored ports, and unmapped addresses both near and far from the mapped range. This separates a wrong constant from a decode that is too wide or too narrow. Write data carries set bits above the stored field, so truncation errors and wrong bit positions show up. The data also toggles between set and clear to tell a sticky bit from a correct one. Pulse and error outputs are checked both in the cycle after the write and in the cycle after that. This catches a pulse that is too long as well as one that never appears. Writes to read-only ports are followed by checks of every level output and of the error flag.

// File: rtl/sysport_pkg.sv
package sysport_pkg;

  localparam int LOCK_CNT = 2;
  localparam int CODE_W   = 8;

  typedef enum logic [3:0] {
    PS_NONE, PS_SPECIAL, PS_CPUCFG, PS_FEAT, PS_STAT, PS_LIGHT, PS_EQUIP,
    PS_LOCK1, PS_LOCK2, PS_L2INV, PS_KEY, PS_SYSCTL, PS_CACHE, PS_MAPMODE
  } port_e;

  // Address to port class; the port numbers are fixed by the board software.
  function automatic port_e classify(input logic [15:0] a);
    case (a)
      16'h0092: return PS_SPECIAL;
      16'h0800: return PS_CPUCFG;
      16'h0802: return PS_FEAT;
      16'h0803: return PS_STAT;
      16'h0808: return PS_LIGHT;
      16'h080C: return PS_EQUIP;
      16'h0810: return PS_LOCK1;
      16'h0812: return PS_LOCK2;
      16'h0814: return PS_L2INV;
      16'h0818: return PS_KEY;
      16'h081C: return PS_SYSCTL;
      16'h0823: return PS_CACHE;
      16'h0850: return PS_MAPMODE;
      default:  return PS_NONE;
    endcase
  endfunction

  function automatic logic wr_accepted(input port_e p);
    case (p)
      PS_SPECIAL, PS_CPUCFG, PS_FEAT, PS_STAT, PS_LIGHT, PS_LOCK1,
      PS_LOCK2, PS_L2INV, PS_SYSCTL, PS_MAPMODE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic rd_mapped(input port_e p);
    case (p)
      PS_SPECIAL, PS_CPUCFG, PS_FEAT, PS_STAT, PS_EQUIP, PS_LOCK1,
      PS_KEY, PS_SYSCTL, PS_CACHE, PS_MAPMODE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [CODE_W-1:0] fixed_code(input port_e p);
    case (p)
      PS_CPUCFG: return 8'hEF;
      PS_FEAT:   return 8'hAD;
      PS_STAT:   return 8'hE0;
      PS_EQUIP:  return 8'h3C;
      PS_LOCK1:  return 8'h39;
      PS_CACHE:  return 8'h03;
      default:   return 8'h00;
    endcase
  endfunction

  function automatic port_e lock_sel(input int i);
    return (i == 0) ? PS_LOCK1 : PS_LOCK2;
  endfunction

endpackage

// File: rtl/sysport_decode.sv
module sysport_decode
  import sysport_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output port_e             sel,
  output logic              wr_hit,
  output logic              wr_miss,
  output logic              rd_req
);

  logic [15:0] addr_ext;

  assign addr_ext = 16'(addr);
  assign sel      = classify(addr_ext);
  assign wr_hit   = wr && wr_accepted(sel);
  assign wr_miss  = wr && !wr_accepted(sel);
  assign rd_req   = rd;

endmodule

// File: rtl/sysport_state.sv
module sysport_state
  import sysport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  port_e               sel,
  input  logic                wr_en,
  input  logic                wr_bad,
  input  logic [DATA_W-1:0]   wdata,
  output logic                soft_rst,
  output logic                le_mode,
  output logic                disk_led,
  output logic [LOCK_CNT-1:0] lock_pulse,
  output logic [CTL_W-1:0]    sys_ctl,
  output logic                io_map,
  output logic                wr_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      soft_rst <= 1'b0;
      le_mode  <= 1'b0;
      disk_led <= 1'b0;
      sys_ctl  <= '0;
      io_map   <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      wr_err <= wr_bad;
      if (wr_en) begin
        case (sel)
          PS_SPECIAL: begin
            soft_rst <= wdata[0];
            le_mode  <= wdata[1];
          end
          PS_LIGHT:   disk_led <= wdata[0];
          PS_SYSCTL:  sys_ctl  <= wdata[CTL_W-1:0];
          PS_MAPMODE: io_map   <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < LOCK_CNT; i++) begin : g_lock
    always_ff @(posedge clk) begin
      if (!rst_n) lock_pulse[i] <= 1'b0;
      else        lock_pulse[i] <= wr_en && (sel == lock_sel(i));
    end

    // R4: a pulse ends after one cycle unless a fresh write to its port arrives
    p_lock_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_pulse[i] && !(wr_en && sel == lock_sel(i))) |=> !lock_pulse[i]);
  end

  p_lock_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lock_pulse));

  p_softrst_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == PS_SPECIAL) |=> $stable(soft_rst) && $stable(le_mode));

  p_sysctl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel == PS_SYSCTL) |=> $stable(sys_ctl));

  p_ro_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel inside {PS_CPUCFG, PS_FEAT, PS_STAT})
      |=> $stable({soft_rst, le_mode, disk_led, sys_ctl, io_map})
          && (lock_pulse == '0) && !wr_err);

  p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> (lock_pulse == '0));

endmodule

// File: rtl/sysport_rdmux.sv
module sysport_rdmux
  import sysport_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  port_e             sel,
  input  logic [CTL_W-1:0]  sys_ctl,
  input  logic              io_map,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rd_next;

  always_comb begin
    case (sel)
      PS_SYSCTL:  rd_next = DATA_W'(sys_ctl);
      PS_MAPMODE: rd_next = DATA_W'(io_map);
      default:    rd_next = rd_mapped(sel) ? DATA_W'(fixed_code(sel)) : '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_next;
  end

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata));

  p_cpucfg_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == PS_CPUCFG) |=> (rdata == DATA_W'(8'hEF)));

  p_l2inv_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == PS_L2INV) |=> (rdata == '1));

endmodule

// File: rtl/sysport_ctrl.sv
module sysport_ctrl
  import sysport_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int CTL_W  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                soft_rst_o,
  output logic                le_mode_o,
  output logic                disk_led_o,
  output logic [LOCK_CNT-1:0] nv_lock_pulse_o,
  output logic [CTL_W-1:0]    sys_ctl_o,
  output logic                io_noncontig_o,
  output logic                wr_err_o
);

  port_e sel;
  logic  wr_hit;
  logic  wr_miss;
  logic  rd_req;

  sysport_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .sel     (sel),
    .wr_hit  (wr_hit),
    .wr_miss (wr_miss),
    .rd_req  (rd_req)
  );

  sysport_state #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .wr_en      (wr_hit),
    .wr_bad     (wr_miss),
    .wdata      (bus_wdata),
    .soft_rst   (soft_rst_o),
    .le_mode    (le_mode_o),
    .disk_led   (disk_led_o),
    .lock_pulse (nv_lock_pulse_o),
    .sys_ctl    (sys_ctl_o),
    .io_map     (io_noncontig_o),
    .wr_err     (wr_err_o)
  );

  sysport_rdmux #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd      (rd_req),
    .sel     (sel),
    .sys_ctl (sys_ctl_o),
    .io_map  (io_noncontig_o),
    .rdata   (bus_rdata)
  );

  // R10: an error flag only follows a write the decoder rejected
  p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |-> $past(bus_wr));

endmodule

// File: tb/sysport_ctrl_tb.sv
module sysport_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        soft_rst_o, le_mode_o, disk_led_o, io_noncontig_o, wr_err_o;
  logic [1:0]  nv_lock_pulse_o;
  logic [3:0]  sys_ctl_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sysport_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .soft_rst_o(soft_rst_o), .le_mode_o(le_mode_o), .disk_led_o(disk_led_o),
    .nv_lock_pulse_o(nv_lock_pulse_o), .sys_ctl_o(sys_ctl_o),
    .io_noncontig_o(io_noncontig_o), .wr_err_o(wr_err_o)
  );

  // {is_read, port, data_or_expect, requirement number}
  localparam int NV = 24;
  localparam logic [24:0] VEC [NV] = '{
    {1'b1, 12'h092, 8'h00, 4'd2},   // R2
    {1'b1, 12'h800, 8'hEF, 4'd7},   // R7
    {1'b1, 12'h802, 8'hAD, 4'd7},
    {1'b1, 12'h803, 8'hE0, 4'd7},
    {1'b1, 12'h80C, 8'h3C, 4'd7},
    {1'b1, 12'h810, 8'h39, 4'd7},
    {1'b1, 12'h823, 8'h03, 4'd7},
    {1'b1, 12'h818, 8'h00, 4'd7},
    {1'b1, 12'h814, 8'hFF, 4'd9},   // R9
    {1'b1, 12'h808, 8'hFF, 4'd9},
    {1'b1, 12'h812, 8'hFF, 4'd9},
    {1'b1, 12'h123, 8'hFF, 4'd9},
    {1'b1, 12'h81C, 8'h00, 4'd1},   // R1
    {1'b1, 12'h850, 8'h00, 4'd1},
    {1'b0, 12'h81C, 8'hF5, 4'd5},   // R5
    {1'b1, 12'h81C, 8'h05, 4'd5},
    {1'b0, 12'h81C, 8'h0A, 4'd5},
    {1'b1, 12'h81C, 8'h0A, 4'd5},
    {1'b0, 12'h850, 8'h03, 4'd6},   // R6
    {1'b1, 12'h850, 8'h01, 4'd6},
    {1'b0, 12'h800, 8'h55, 4'd8},   // R8
    {1'b1, 12'h800, 8'hEF, 4'd8},
    {1'b0, 12'h850, 8'hFE, 4'd6},
    {1'b1, 12'h850, 8'h00, 4'd6}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Write: after this returns, the edge that took the write has passed.
  task automatic do_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [11:0] a);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] levels();
    return {24'd0, soft_rst_o, le_mode_o, disk_led_o, io_noncontig_o, sys_ctl_o};
  endfunction

  initial begin
    logic [31:0] snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", levels(), 32'd0);
    chk("R1", {nv_lock_pulse_o, wr_err_o, bus_rdata}, 32'd0);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][24]) begin
        do_rd(VEC[k][23:12]);
        chk($sformatf("R%0d", VEC[k][3:0]), bus_rdata, VEC[k][11:4]);
      end else begin
        do_wr(VEC[k][23:12], VEC[k][11:4]);
      end
    end

    // R2 special port levels
    do_wr(12'h092, 8'hFF);
    chk("R2", {soft_rst_o, le_mode_o}, 2'b11);
    do_wr(12'h092, 8'h02);
    chk("R2", {soft_rst_o, le_mode_o}, 2'b01);
    do_wr(12'h092, 8'h01);
    chk("R2", {soft_rst_o, le_mode_o}, 2'b10);
    // R3 lamp
    do_wr(12'h808, 8'h01);
    chk("R3", disk_led_o, 1);
    do_wr(12'h808, 8'hFE);
    chk("R3", disk_led_o, 0);
    // R6 map level
    do_wr(12'h850, 8'h01);
    chk("R6", io_noncontig_o, 1);
    // R5 sys ctl level
    do_wr(12'h81C, 8'h3C);
    chk("R5", sys_ctl_o, 4'hC);
    // R4 lock pulses
    do_wr(12'h810, 8'h00);
    chk("R4", nv_lock_pulse_o, 2'b01);
    @(negedge clk);
    chk("R4", nv_lock_pulse_o, 2'b00);
    do_wr(12'h812, 8'hA5);
    chk("R4", nv_lock_pulse_o, 2'b10);
    @(negedge clk);
    chk("R4", nv_lock_pulse_o, 2'b00);
    // R10 unmapped write error, one cycle, no side effect
    snap = levels();
    do_wr(12'h818, 8'hFF);
    chk("R10", {wr_err_o, nv_lock_pulse_o}, 3'b100);
    chk("R10", levels(), snap);
    @(negedge clk);
    chk("R10", wr_err_o, 0);
    do_wr(12'h814, 8'hFF);
    chk("R10", wr_err_o, 0);
    chk("R10", levels(), snap);
    // R8 read-only writes ignored
    do_wr(12'h802, 8'h00);
    chk("R8", {wr_err_o, nv_lock_pulse_o}, 3'b000);
    chk("R8", levels(), snap);
    do_wr(12'h803, 8'hFF);
    chk("R8", levels(), snap);
    do_rd(12'h803);
    chk("R8", bus_rdata, 8'hE0);
    // R11 read data held while idle, and after a write
    do_rd(12'h81C);
    chk("R11", bus_rdata, 8'h0C);
    do_wr(12'h81C, 8'h07);
    repeat (3) @(negedge clk);
    chk("R11", bus_rdata, 8'h0C);
    // R1 reset again after state was set
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", levels(), 32'd0);
    chk("R1", bus_rdata, 8'h00);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule